// File: doc/BRIEF.md
# Software-Triggered Peripheral Reset Pulser

This block lets software pulse reset into a chosen group of peripheral subsystems through a small register-mapped interface. Two register windows are decoded on a single-cycle bus with address, write enable, write data and combinational read data. The first window holds a line-selection register. The second window holds a trigger register, which carries a start flag and a pulse-delay field.

Software first writes the selection and then sets the start flag. The block captures the selection as it stands at that moment. It drives the chosen active-high reset outputs for (delay + 1) × 16 clock cycles, lowers them, and then clears the start flag. Software polls the flag to learn that the pulse has finished.

A three-state sequencer runs the pulse:
- **IDLE** waits for a start request. Transition *launch* goes IDLE→PULSE when a start write arrives.
- **PULSE** counts the pulse length down. Transition *expire* goes PULSE→RELEASE when the count reaches zero, and this drops the outputs.
- **RELEASE** keeps the start flag high for one more cycle while the outputs are already low. Transition *settle* goes RELEASE→IDLE.

Top module: `periph_reset_pulser`

## Requirements
- R1: After system reset every reset output is low, and both the selection register and the trigger register read 0.
- R2: The selection register sits at address 0x000. Line k (k = 0..8, in the order APB, AXI, Ethernet, USB, SDIO, HDMI, graphics, DMA controller, external bus interface) is selected by bit 16+k for k ≤ 6, by bit 25 for k = 7 and by bit 31 for k = 8. All other bits read 0 and ignore writes, so writing 0xFFFFFFFF reads back 0x827F0000.
- R3: Any address other than 0x000 and 0x100 reads 0. A write to such an address changes neither register and starts no pulse.
- R4: The trigger register sits at address 0x100. A write with bit 0 = 1 while idle drives periph_rst[k] high, for exactly the selected lines k, from the cycle after the write. Every other line stays low.
- R5: A pulse lasts exactly (D + 1) × 16 cycles, where D is bits 31:16 of the start write. D = 0 gives 16 cycles.
- R6: Bit 0 of the trigger register reads 1 from the cycle after the start write. It returns to 0 exactly one cycle after the reset outputs fall.
- R7: The line mask is captured at the start write. Writes to the selection register during a pulse are stored but do not change the running pulse.
- R8: A start write during a pulse neither restarts nor extends it. Its delay field is still stored and reads back, and it takes effect only on a later pulse.
- R9: A trigger write with bit 0 = 0 stores the delay field, which reads back in bits 31:16, and starts no pulse.
- R10: The reset outputs come straight from flops. They change only at the start and at the end of a pulse, and the captured mask stays constant while the pulse runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write enable, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register (combinational) |
| periph_rst | output | 9 | Active-high reset outputs, one per peripheral line |

## Verification
Each kind of internal fault shows up at the ports within one pulse:
- A wrong sequencer state or count changes the number of cycles the outputs stay high, or the gap between the outputs falling and the start flag clearing. Both are measured to the cycle at the ports.
- A wrong captured mask shows up as a different set of high outputs, or as a mask that moves during a pulse.
- A decode fault shows up on the next read of the selection register, the trigger register or an unmapped address.

// File: rtl/rp_pkg.sv
package rp_pkg;

    localparam int unsigned NUM_LINES = 9;
    localparam int unsigned REG_W     = 32;

    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_PULSE   = 2'd1,
        S_RELEASE = 2'd2
    } seq_state_e;

    // Bit position of each reset line inside the selection register.
    function automatic int unsigned line_bit(input int unsigned idx);
        int unsigned pos;
        if (idx < 7)       pos = 16 + idx;
        else if (idx == 7) pos = 25;
        else               pos = 31;
        return pos;
    endfunction

endpackage

// File: rtl/rp_regs.sv
module rp_regs
    import rp_pkg::*;
#(
    parameter int unsigned AW        = 12,
    parameter int unsigned DELAY_W   = 16,
    parameter logic [AW-1:0] SEL_ADDR  = 12'h000,
    parameter logic [AW-1:0] TRIG_ADDR = 12'h100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    input  logic                 busy,
    output logic [NUM_LINES-1:0] sel_q,
    output logic [DELAY_W-1:0]   delay_q,
    output logic                 start_req,
    output logic [DELAY_W-1:0]   start_delay,
    output logic [REG_W-1:0]     bus_rdata
);
    localparam int unsigned DLY_LSB = REG_W - DELAY_W;

    logic                 hit_sel, hit_trig;
    logic                 wr_sel, wr_trig;
    logic [NUM_LINES-1:0] sel_wr_bits;
    logic [REG_W-1:0]     sel_view;
    logic [REG_W-1:0]     trig_view;
    logic                 unused_wdata;

    assign hit_sel  = (bus_addr == SEL_ADDR);
    assign hit_trig = (bus_addr == TRIG_ADDR);
    assign wr_sel   = hit_sel  & bus_we;
    assign wr_trig  = hit_trig & bus_we;
    assign unused_wdata = ^bus_wdata;

    // Scatter and gather between compact line index and sparse bus bits.
    always_comb begin
        sel_view = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            sel_view[line_bit(i)] = sel_q[i];
        end
    end

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_gather
            localparam int unsigned POS = line_bit(g);
            assign sel_wr_bits[g] = bus_wdata[POS];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else if (wr_sel) begin
            sel_q <= sel_wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            delay_q <= '0;
        end else if (wr_trig) begin
            delay_q <= bus_wdata[REG_W-1:DLY_LSB];
        end
    end

    assign start_req   = wr_trig & bus_wdata[0];
    assign start_delay = bus_wdata[REG_W-1:DLY_LSB];

    always_comb begin
        trig_view = '0;
        trig_view[REG_W-1:DLY_LSB] = delay_q;
        trig_view[0] = busy;
    end

    always_comb begin
        bus_rdata = '0;
        if (hit_sel)       bus_rdata = sel_view;
        else if (hit_trig) bus_rdata = trig_view;
    end

    p_delay_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_trig |=> delay_q == $past(bus_wdata[REG_W-1:DLY_LSB]));

    p_sel_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(sel_q));

endmodule

// File: rtl/rp_seq.sv
module rp_seq
    import rp_pkg::*;
#(
    parameter int unsigned DELAY_W    = 16,
    parameter int unsigned TICK_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic [DELAY_W-1:0] start_delay,
    output logic               busy,
    output logic               load_o,
    output logic               drop_o
);
    localparam int unsigned CNT_W = DELAY_W + TICK_SHIFT;

    seq_state_e       state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic             cnt_zero;

    assign cnt_zero = (cnt == '0);

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions: launch, expire, settle.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start_req) state_nx = S_PULSE;
            S_PULSE:   if (cnt_zero)  state_nx = S_RELEASE;
            S_RELEASE: state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Length counter: loaded with (D+1)*2^TICK_SHIFT - 1.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (state == S_IDLE && start_req) begin
            cnt <= {start_delay, {TICK_SHIFT{1'b1}}};
        end else if (state == S_PULSE && !cnt_zero) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    // Outputs.
    always_comb begin
        busy   = 1'b0;
        load_o = 1'b0;
        drop_o = 1'b0;
        unique case (state)
            S_IDLE:    load_o = start_req;
            S_PULSE:   begin busy = 1'b1; drop_o = cnt_zero; end
            S_RELEASE: busy = 1'b1;
            default:   busy = 1'b0;
        endcase
    end

    p_cnt_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PULSE && !cnt_zero) |=> (state == S_PULSE && cnt == $past(cnt) - CNT_W'(1)));

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && start_req) |=> state != S_PULSE || cnt != {CNT_W{1'b1}} || $past(cnt) == {CNT_W{1'b0}});

    p_settle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_RELEASE |=> state == S_IDLE);

    p_launch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start_req) |=> state == S_PULSE);

endmodule

// File: rtl/rp_out_stage.sv
module rp_out_stage
    import rp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic                 drop_i,
    input  logic [NUM_LINES-1:0] mask_i,
    output logic [NUM_LINES-1:0] rst_o
);
    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      q <= 1'b0;
                else if (load_i) q <= mask_i[g];
                else if (drop_i) q <= 1'b0;
            end
            assign rst_o[g] = q;
        end
    endgenerate

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !drop_i) |=> $stable(rst_o));

    p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_i && !load_i) |=> rst_o == '0);

endmodule

// File: rtl/periph_reset_pulser.sv
module periph_reset_pulser
    import rp_pkg::*;
#(
    parameter int unsigned AW         = 12,
    parameter int unsigned DELAY_W    = 16,
    parameter int unsigned TICK_SHIFT = 4,
    parameter logic [AW-1:0] SEL_ADDR  = 12'h000,
    parameter logic [AW-1:0] TRIG_ADDR = 12'h100
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [AW-1:0]        bus_addr,
    input  logic                 bus_we,
    input  logic [REG_W-1:0]     bus_wdata,
    output logic [REG_W-1:0]     bus_rdata,
    output logic [NUM_LINES-1:0] periph_rst
);
    logic [NUM_LINES-1:0] sel_q;
    logic [DELAY_W-1:0]   delay_q;
    logic                 start_req;
    logic [DELAY_W-1:0]   start_delay;
    logic                 busy, load, drop;
    logic                 unused_delay;

    assign unused_delay = ^delay_q;

    rp_regs #(
        .AW(AW), .DELAY_W(DELAY_W), .SEL_ADDR(SEL_ADDR), .TRIG_ADDR(TRIG_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .busy(busy), .sel_q(sel_q), .delay_q(delay_q),
        .start_req(start_req), .start_delay(start_delay),
        .bus_rdata(bus_rdata)
    );

    rp_seq #(
        .DELAY_W(DELAY_W), .TICK_SHIFT(TICK_SHIFT)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_req(start_req), .start_delay(start_delay),
        .busy(busy), .load_o(load), .drop_o(drop)
    );

    rp_out_stage u_out (
        .clk(clk), .rst_n(rst_n),
        .load_i(load), .drop_i(drop), .mask_i(sel_q),
        .rst_o(periph_rst)
    );

    p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> periph_rst == '0);

    p_launch_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && !busy) |=> (busy && periph_rst == $past(sel_q)));

endmodule

// File: tb/periph_reset_pulser_tb.sv
module periph_reset_pulser_tb;
    localparam logic [11:0] SEL  = 12'h000;
    localparam logic [11:0] TRIG = 12'h100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [8:0]  prst;

    always #5 clk = ~clk;

    periph_reset_pulser u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .periph_rst(prst)
    );

    int n_cmp = 0, n_bad = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sel_word(input logic [8:0] s);
        logic [31:0] w = '0;
        for (int i = 0; i < 9; i++) begin
            int p = (i < 7) ? 16 + i : (i == 7 ? 25 : 31);
            w[p] = s[i];
        end
        return w;
    endfunction

    // Port monitor: measures pulse length, mask and fall cycle.
    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [8:0] prev_out = '0, cur_mask = '0, last_mask = '0;
    int cur_len = 0, last_len = 0, pulses = 0;
    int unsigned fall_cyc = 0;
    bit cur_chg = 0, last_chg = 0;

    always @(negedge clk) begin
        if (prst != 0) begin
            if (prev_out == 0) begin
                cur_len = 1; cur_mask = prst; cur_chg = 0;
            end else begin
                cur_len++;
                if (prst != cur_mask) cur_chg = 1;
            end
        end else if (prev_out != 0) begin
            last_len = cur_len; last_mask = cur_mask; last_chg = cur_chg;
            fall_cyc = cyc; pulses++;
        end
        prev_out = prst;
    end

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_done(output int unsigned clr);
        logic [31:0] d;
        clr = 0;
        for (int i = 0; i < 100000; i++) begin
            bus_read(TRIG, d);
            if (d[0] == 1'b0) begin
                clr = cyc;
                break;
            end
        end
    endtask

    task automatic run_pulse(input logic [8:0] s, input int dly);
        logic [31:0] d;
        int unsigned clr;
        int p0 = pulses;
        bus_write(SEL, sel_word(s));
        bus_write(TRIG, {dly[15:0], 16'h0001});
        bus_read(TRIG, d);
        check("R6 start flag high during pulse", {31'b0, d[0]}, 32'd1);
        wait_done(clr);
        if (s != 0) begin
            check("R4 pulse count", pulses, p0 + 1);
            check("R4 pulse mask", {23'b0, last_mask}, {23'b0, s});
            check("R5 pulse length", last_len, (dly + 1) * 16);
            check("R6 flag clears one cycle after fall", clr - fall_cyc, 32'd1);
            check("R10 mask steady", {31'b0, last_chg}, 32'd0);
        end else begin
            check("R4 empty mask drives nothing", pulses, p0);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int unsigned clr;
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 outputs low", {23'b0, prst}, 32'd0);
        bus_read(SEL, d);  check("R1 selection zero", d, 32'd0);
        bus_read(TRIG, d); check("R1 trigger zero", d, 32'd0);

        // R2 sparse selection mapping
        bus_write(SEL, 32'hFFFF_FFFF);
        bus_read(SEL, d);  check("R2 all-ones readback", d, 32'h827F_0000);
        bus_write(SEL, 32'h7D80_FFFF);
        bus_read(SEL, d);  check("R2 unmapped bits ignored", d, 32'h0);
        for (int k = 0; k < 9; k++) begin
            bus_write(SEL, sel_word(9'(1 << k)));
            bus_read(SEL, d);
            check("R2 single line readback", d, sel_word(9'(1 << k)));
        end

        // R3 unmapped addresses
        p0 = pulses;
        bus_write(SEL, sel_word(9'h155));
        bus_write(12'h004, 32'hFFFF_FFFF);
        bus_write(12'h104, 32'hFFFF_FFFF);
        bus_write(12'h0FC, 32'hFFFF_FFFF);
        bus_read(12'h004, d); check("R3 unmapped reads zero", d, 32'h0);
        bus_read(12'h104, d); check("R3 unmapped reads zero", d, 32'h0);
        bus_read(SEL, d);     check("R3 selection untouched", d, sel_word(9'h155));
        bus_read(TRIG, d);    check("R3 trigger untouched", d, 32'h0);
        repeat (20) @(negedge clk);
        check("R3 no pulse", pulses, p0);

        // R9 delay write without start
        bus_write(TRIG, 32'h0005_0000);
        bus_read(TRIG, d); check("R9 delay stored", d, 32'h0005_0000);
        repeat (40) @(negedge clk);
        check("R9 no pulse", pulses, p0);
        check("R9 outputs low", {23'b0, prst}, 32'd0);

        // R4 R5 R6 sweep over delays and masks
        for (int dl = 0; dl < 3; dl++) begin
            for (int k = 0; k < 9; k++) run_pulse(9'(1 << k), dl);
            run_pulse(9'h1FF, dl);
            run_pulse(9'h155, dl);
            run_pulse(9'h0AA, dl);
            run_pulse(9'h000, dl);
        end
        run_pulse(9'h1FF, 20);

        // R7 R8 changes during a running pulse
        p0 = pulses;
        bus_write(SEL, sel_word(9'h00F));
        bus_write(TRIG, 32'h0001_0001);
        repeat (3) @(negedge clk);
        bus_write(SEL, 32'hFFFF_FFFF);
        bus_write(TRIG, 32'h0003_0001);
        bus_read(TRIG, d); check("R8 delay stored while busy", d, 32'h0003_0001);
        wait_done(clr);
        check("R8 single pulse", pulses, p0 + 1);
        check("R8 not extended", last_len, 32);
        check("R7 mask latched", {23'b0, last_mask}, 32'h00F);
        check("R7 mask steady", {31'b0, last_chg}, 32'd0);
        bus_read(SEL, d); check("R7 new selection stored", d, 32'h827F_0000);
        bus_read(TRIG, d); check("R8 stored delay after pulse", d, 32'h0003_0000);
        run_pulse(9'h1FF, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule